// File: doc/BRIEF.md
# Signal-Loss Autonomous Pattern Generator

This block watches the serial data input of an LED driver node. When no valid input activity has been seen for a set number of clock cycles, it takes over the node. The node then counts as being in internal mode. It steps the local red, green and blue channels through a fixed seven-entry colour sequence and shows the channel on/off state on `rgb_on`. At the same time it sends a generated serial pixel stream on `dout`, using the same pulse-width bit coding as normal traffic, so that every node further down the chain shows the same colours in step.

Input activity counts only when the activity qualifier `din_act` is high in the same cycle that `din` rises, meaning `din` was sampled low on the clock edge before. A long low level on `din` is therefore seen as a lost signal and not as a latch command. One valid rising edge while the block is in internal mode hands the node back to external control on the next clock edge. It also restarts the loss timer.

The stream is built from bursts. Each burst holds a parameterised number of 24-bit words and ends with a low gap that is long enough to act as a latch pause at the downstream nodes. All of the words in a burst carry the colour that was current when the burst began.

Top module: `sig_loss_pattern_gen`

## Requirements
- R1: While reset is held, and at every time the block is in external mode, `internal_mode`, `rgb_on` and `dout` are all 0.
- R2: After reset, if no valid event occurs, `internal_mode` rises right after the TIMEOUT_CYC-th rising clock edge that follows reset release.
- R3: A valid event is defined as `din_act` being high while `din` is 1 and `din` was sampled 0 on the edge before. A valid event restarts the loss count, so entry happens TIMEOUT_CYC edges after the edge that sampled the event.
- R4: A rising edge on `din` while `din_act` is low does not count as an event and has no effect on the entry time. Holding `din_act` high while `din` stays high also has no effect on the entry time.
- R5: In internal mode, `rgb_on` (bit 2 = red, bit 1 = green, bit 0 = blue) steps through these on-sets in order, each held for DWELL_CYC cycles: red, green, blue, red+green, red+blue, green+blue, red+green+blue. The sequence starts with red in the first internal cycle and wraps back to red after the seventh entry.
- R6: Each serial bit occupies BIT_CYC cycles. `dout` is high for the first T1H_CYC cycles of the slot for a 1, or for the first T0H_CYC cycles for a 0, and is low for the rest of the slot.
- R7: Each word is 24 bits: the red byte, then the green byte, then the blue byte. A byte is 0xFF when its channel is on and 0x00 when it is off. The on/off state used is the `rgb_on` value of the first cycle of the burst.
- R8: A burst is WORD_CNT words sent back to back, followed by GAP_CYC cycles with `dout` low. The next burst starts right after the gap. The first burst starts in the first internal cycle.
- R9: A valid event in internal mode clears `internal_mode`, `rgb_on` and `dout` from the next edge on. The block then re-enters internal mode TIMEOUT_CYC edges later, with the sequence and the stream restarted from their first position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Serial data input line |
| din_act | input | 1 | Qualifier for input activity |
| internal_mode | output | 1 | High while the block drives the node itself |
| rgb_on | output | 3 | Channel on state: bit 2 red, bit 1 green, bit 0 blue |
| dout | output | 1 | Generated serial stream for the downstream node |

## Verification
The loss timer is tested with a quiet line, with one qualified rising edge partway through the count, and with two kinds of near-events: an unqualified rising edge, and a qualifier held high while `din` stays high. The entry edge tells apart a timer that restarts from one that ignores or miscounts these inputs. The internal phase is compared cycle by cycle against an arithmetic model across several bursts and several full wraps of the colour sequence. That comparison separates mistakes in pulse width, byte order, burst length, gap length and the latching of the colour at each burst start. A qualified edge is then given during internal mode. It checks the immediate exit, the restarted timeout, and that the sequence and stream restart from their first position.

// File: rtl/sig_loss_pkg.sv
package sig_loss_pkg;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_GAP  = 1'b1
    } tx_phase_t;

    localparam int unsigned N_STATES = 7;

    // Table is kept in off-form: a set bit turns that channel off.
    function automatic logic [2:0] state_off(input logic [2:0] idx);
        logic [2:0] off;
        case (idx)
            3'd0:    off = 3'b011;
            3'd1:    off = 3'b101;
            3'd2:    off = 3'b110;
            3'd3:    off = 3'b001;
            3'd4:    off = 3'b010;
            3'd5:    off = 3'b100;
            default: off = 3'b000;
        endcase
        return off;
    endfunction

    function automatic logic [2:0] state_on(input logic [2:0] idx);
        return ~state_off(idx);
    endfunction

endpackage

// File: rtl/loss_timer.sv
module loss_timer #(
    parameter int unsigned TIMEOUT_CYC = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic din_act,
    output logic internal_mode
);
    localparam int unsigned CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic          din_prev;
        logic [CW-1:0] cnt;
        logic          internal;
    } lt_state_t;

    lt_state_t s_d, s_q;
    logic      hit;

    assign hit = din_act && din && !s_q.din_prev;

    always_comb begin
        s_d          = s_q;
        s_d.din_prev = din;
        if (hit) begin
            s_d.cnt      = '0;
            s_d.internal = 1'b0;
        end else if (s_q.internal) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == CNT_LAST) begin
            s_d.cnt      = '0;
            s_d.internal = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign internal_mode = s_q.internal;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_LAST);
    assert_entry_after_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.internal) |-> $past(s_q.cnt) == CNT_LAST);
    assert_event_exits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (din_act && din && !s_q.din_prev) |=> !internal_mode);

endmodule

// File: rtl/pattern_seq.sv
module pattern_seq #(
    parameter int unsigned DWELL_CYC = 100_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic [2:0] rgb_on,
    output logic [2:0] nxt_on
);
    import sig_loss_pkg::*;

    localparam int unsigned DW = (DWELL_CYC > 2) ? $clog2(DWELL_CYC) : 1;
    localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL_CYC - 1);
    localparam logic [2:0]    IDX_LAST   = 3'(N_STATES - 1);

    typedef struct packed {
        logic [DW-1:0] dwell;
        logic [2:0]    idx;
    } ps_state_t;

    ps_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d = '0;
        end else if (s_q.dwell == DWELL_LAST) begin
            s_d.dwell = '0;
            s_d.idx   = (s_q.idx == IDX_LAST) ? 3'd0 : s_q.idx + 3'd1;
        end else begin
            s_d.dwell = s_q.dwell + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rgb_on = run ? state_on(s_q.idx) : 3'b000;
    assign nxt_on = state_on(s_d.idx);

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= IDX_LAST);
    assert_dwell_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(s_q.dwell) != DWELL_LAST) |-> $stable(s_q.idx));

endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
    parameter int unsigned BIT_CYC  = 200,
    parameter int unsigned T0H_CYC  = 60,
    parameter int unsigned T1H_CYC  = 120,
    parameter int unsigned WORD_CNT = 2048,
    parameter int unsigned GAP_CYC  = 30_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] nxt_on,
    output logic       dout
);
    import sig_loss_pkg::*;

    localparam int unsigned BW = (BIT_CYC  > 2) ? $clog2(BIT_CYC)  : 1;
    localparam int unsigned WW = (WORD_CNT > 2) ? $clog2(WORD_CNT) : 1;
    localparam int unsigned GW = (GAP_CYC  > 2) ? $clog2(GAP_CYC)  : 1;
    localparam logic [BW-1:0] BIT_LAST  = BW'(BIT_CYC - 1);
    localparam logic [WW-1:0] WORD_LAST = WW'(WORD_CNT - 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);
    localparam logic [4:0]    POS_LAST  = 5'd23;

    typedef struct packed {
        tx_phase_t     phase;
        logic [BW-1:0] bcyc;
        logic [4:0]    pos;
        logic [WW-1:0] word;
        logic [GW-1:0] gap;
        logic [2:0]    pat;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic      bit_val;

    always_comb begin
        case (s_q.pos[4:3])
            2'd0:    bit_val = s_q.pat[2];
            2'd1:    bit_val = s_q.pat[1];
            default: bit_val = s_q.pat[0];
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d     = '0;
            s_d.pat = nxt_on;
        end else if (s_q.phase == PH_DATA) begin
            if (s_q.bcyc == BIT_LAST) begin
                s_d.bcyc = '0;
                if (s_q.pos == POS_LAST) begin
                    s_d.pos = '0;
                    if (s_q.word == WORD_LAST) begin
                        s_d.word  = '0;
                        s_d.gap   = '0;
                        s_d.phase = PH_GAP;
                    end else begin
                        s_d.word = s_q.word + 1'b1;
                    end
                end else begin
                    s_d.pos = s_q.pos + 5'd1;
                end
            end else begin
                s_d.bcyc = s_q.bcyc + 1'b1;
            end
        end else begin
            if (s_q.gap == GAP_LAST) begin
                s_d.gap   = '0;
                s_d.phase = PH_DATA;
                s_d.pat   = nxt_on;
            end else begin
                s_d.gap = s_q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = run && (s_q.phase == PH_DATA) &&
                  (int'(s_q.bcyc) < (bit_val ? int'(T1H_CYC) : int'(T0H_CYC)));

    assert_word_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.word <= WORD_LAST);
    assert_pos_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pos <= POS_LAST);
    assert_colour_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(s_q.phase) == PH_DATA) |-> $stable(s_q.pat));

endmodule

// File: rtl/sig_loss_pattern_gen.sv
module sig_loss_pattern_gen #(
    parameter int unsigned TIMEOUT_CYC = 30_000_000,
    parameter int unsigned DWELL_CYC   = 100_000_000,
    parameter int unsigned BIT_CYC     = 200,
    parameter int unsigned T0H_CYC     = 60,
    parameter int unsigned T1H_CYC     = 120,
    parameter int unsigned WORD_CNT    = 2048,
    parameter int unsigned GAP_CYC     = 30_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic       din_act,
    output logic       internal_mode,
    output logic [2:0] rgb_on,
    output logic       dout
);
    logic [2:0] nxt_on;

    loss_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .din(din), .din_act(din_act),
        .internal_mode(internal_mode)
    );

    pattern_seq #(.DWELL_CYC(DWELL_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(internal_mode),
        .rgb_on(rgb_on), .nxt_on(nxt_on)
    );

    serial_tx #(
        .BIT_CYC(BIT_CYC), .T0H_CYC(T0H_CYC), .T1H_CYC(T1H_CYC),
        .WORD_CNT(WORD_CNT), .GAP_CYC(GAP_CYC)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .run(internal_mode),
        .nxt_on(nxt_on), .dout(dout)
    );

    assert_quiet_external_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !internal_mode |-> (rgb_on == 3'b000 && !dout));
    assert_lit_internal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        internal_mode |-> rgb_on != 3'b000);

endmodule

// File: tb/sim_sig_loss_pattern_gen.sv
module sim_sig_loss_pattern_gen;
    localparam int TO   = 50;
    localparam int DW   = 37;
    localparam int BC   = 6;
    localparam int T0H  = 2;
    localparam int T1H  = 4;
    localparam int WC   = 2;
    localparam int GAP  = 15;
    localparam int DATA_LEN  = WC * 24 * BC;
    localparam int BURST_LEN = DATA_LEN + GAP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       din_act = 1'b0;
    logic       internal_mode;
    logic [2:0] rgb_on;
    logic       dout;

    int checks = 0;
    int failures = 0;
    int edge_n = 0;

    always #2 clk = ~clk;

    sig_loss_pattern_gen #(
        .TIMEOUT_CYC(TO), .DWELL_CYC(DW), .BIT_CYC(BC), .T0H_CYC(T0H),
        .T1H_CYC(T1H), .WORD_CNT(WC), .GAP_CYC(GAP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .din_act(din_act),
        .internal_mode(internal_mode), .rgb_on(rgb_on), .dout(dout)
    );

    function automatic int exp_rgb(input int c);
        case ((c / DW) % 7)
            0: return 4;
            1: return 2;
            2: return 1;
            3: return 6;
            4: return 5;
            5: return 3;
            default: return 7;
        endcase
    endfunction

    function automatic int exp_dout(input int c);
        int p, on, b, k, v;
        p = c % BURST_LEN;
        on = exp_rgb(c - p);
        if (p >= DATA_LEN) return 0;
        b = (p / BC) % 24;
        k = p % BC;
        v = (on >> (2 - b / 8)) & 1;
        return (k < (v != 0 ? T1H : T0H)) ? 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, edge_n, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        edge_n++;
    endtask

    task automatic run_to(input int target);
        while (edge_n < target) step();
    endtask

    task automatic compare_internal(input int n);
        for (int c = 0; c < n; c++) begin
            check("R5 rgb sequence", int'(rgb_on), exp_rgb(c));
            check("R6/R7/R8 serial stream", int'(dout), exp_dout(c));
            step();
        end
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        check("R1 reset mode", int'(internal_mode), 0);
        check("R1 reset rgb", int'(rgb_on), 0);
        check("R1 reset dout", int'(dout), 0);
        rst_n = 1'b1;

        // R3: qualified edge sampled at edge 10 restarts the count
        run_to(9);
        din = 1'b1; din_act = 1'b1;
        step();
        din = 1'b0; din_act = 1'b0;
        // R4: unqualified rise at edge 30, qualifier with no rise at edge 35
        run_to(29);
        din = 1'b1;
        step();
        run_to(34);
        din_act = 1'b1;
        step();
        din_act = 1'b0;
        run_to(39);
        din = 1'b0;
        run_to(10 + TO - 1);
        check("R3/R4 not yet internal", int'(internal_mode), 0);
        check("R1 external rgb", int'(rgb_on), 0);
        check("R1 external dout", int'(dout), 0);
        step();
        check("R2/R3/R4 entry edge", int'(internal_mode), 1);

        compare_internal(1500);

        // R9: qualified edge during internal mode
        din = 1'b1; din_act = 1'b1;
        step();
        din = 1'b0; din_act = 1'b0;
        e0 = edge_n;
        check("R9 exit mode", int'(internal_mode), 0);
        check("R9 exit rgb", int'(rgb_on), 0);
        check("R9 exit dout", int'(dout), 0);
        run_to(e0 + TO - 1);
        check("R9 re-entry not early", int'(internal_mode), 0);
        step();
        check("R9 re-entry edge", int'(internal_mode), 1);
        compare_internal(700);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule